// File: doc/BRIEF.md
# Dual-Lane Selectable-Polynomial CRC Engine

This block keeps two 16-bit CRC registers that are updated one serial bit per clock: one lane for the transmit path of a synchronous serial channel and one for the receive path. Each lane has its own data bit, bit-enable strobe and preset command. The polynomial choice and the preset-value choice are shared inputs and apply to both lanes alike.

A bit is folded in only when its lane's enable strobe is high. Surrounding logic decides which characters count toward the CRC and drives the strobe to match. The register is never preset by the block on its own. Framing logic must issue the lane's preset command, typically while idle fill is being sent or received.

The transmit lane's register is presented as-is for the serializer to send. The receive lane also drives a flag that goes high when its register holds the residue expected after a frame and its appended CRC have both been folded in.

Top module: `crc_dual_engine`

## Requirements
- R1: Register update: with feedback f = crc[0] XOR bit, the next value is (crc >> 1) XOR (f ? P : 0), where crc[0] is the bit fed in first (LSB-first). P is 16'hA001 (the x^16+x^15+x^2+1 polynomial, bit-reversed) when `poly_sel`=1, and 16'h8408 (x^16+x^12+x^5+1, bit-reversed) when `poly_sel`=0.
- R2: `poly_sel` and `preset_ones` act on both lanes alike, so identical bit streams give identical register values in the two lanes.
- R3: A preset command loads 16'hFFFF when `preset_ones`=1 and 16'h0000 when `preset_ones`=0.
- R4: After `rst_n` is released both registers hold 16'h0000 whatever `preset_ones` is. No preset happens unless the preset command is asserted.
- R5: When a lane's bit enable is low and its preset command is low, its register keeps its value whatever the data bit is.
- R6: When preset command and bit enable are high in the same cycle, the preset value is loaded and the data bit is discarded.
- R7: `rx_residue_ok` is 1 exactly when `rx_crc` equals the expected residue. The residue is 16'h0000 when `preset_ones`=0. When `preset_ones`=1 it is 16'hB001 for `poly_sel`=1 and 16'hF0B8 for `poly_sel`=0. These are the values left after a frame is followed by the ones'-complement of its CRC (ones preset) or by the plain CRC (zero preset), sent LSB first.
- R8: A fold or preset takes effect at the rising clock edge on which it is sampled. The new value appears on the outputs after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both registers |
| poly_sel | input | 1 | 1 selects polynomial 0xA001 (reflected), 0 selects 0x8408 (reflected) |
| preset_ones | input | 1 | Preset value: 1 gives all ones, 0 gives all zeros |
| tx_preset_cmd | input | 1 | Load the preset value into the transmit lane |
| tx_bit_en | input | 1 | Fold `tx_bit` into the transmit lane this cycle |
| tx_bit | input | 1 | Transmit serial data bit |
| rx_preset_cmd | input | 1 | Load the preset value into the receive lane |
| rx_bit_en | input | 1 | Fold `rx_bit` into the receive lane this cycle |
| rx_bit | input | 1 | Receive serial data bit |
| tx_crc | output | 16 | Transmit lane CRC register |
| rx_crc | output | 16 | Receive lane CRC register |
| rx_residue_ok | output | 1 | Receive register equals the expected residue |

## Verification
The bench runs all four combinations of polynomial and preset over a nine-byte ASCII string against known CRC values. A design that swapped the polynomials, fed bits MSB first or used the wrong preset would produce a different register value. It then appends the CRC, complemented for the ones preset, to the receive stream and checks the residue flag. A wrong residue constant, or a flag tied to zero, is caught there. Directed cases cover the remaining behaviour:
- Strobes are gated mid-byte, so a design that folded disabled bits would drift from the model.
- Preset and enable are asserted together; a design that let the data bit through after loading would be wrong.
- The ones preset is selected straight after reset without a command; a design that preset on its own would start from 16'hFFFF.
- Outputs are sampled just before the edge; a design whose output changed early, or only one edge late, would be caught.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int CRC_W = 16;

  typedef logic [CRC_W-1:0] crc_word_t;

  typedef enum logic {
    POLY_CCITT = 1'b0,
    POLY_C16   = 1'b1
  } poly_sel_e;

  // Bit-reversed generator polynomials (register shifts toward bit 0)
  localparam crc_word_t POLY_C16_REFL   = 16'hA001;
  localparam crc_word_t POLY_CCITT_REFL = 16'h8408;

  // Residues left after frame plus complemented CRC, ones preset
  localparam crc_word_t RESID_C16   = 16'hB001;
  localparam crc_word_t RESID_CCITT = 16'hF0B8;

  function automatic crc_word_t poly_mask(input logic sel);
    return (poly_sel_e'(sel) == POLY_C16) ? POLY_C16_REFL : POLY_CCITT_REFL;
  endfunction

  function automatic crc_word_t preset_word(input logic ones);
    return ones ? {CRC_W{1'b1}} : {CRC_W{1'b0}};
  endfunction

  function automatic crc_word_t fold_bit(input crc_word_t cur, input logic d,
                                         input logic sel);
    logic fb;
    fb = cur[0] ^ d;
    return (cur >> 1) ^ (fb ? poly_mask(sel) : {CRC_W{1'b0}});
  endfunction

  function automatic crc_word_t residue_word(input logic sel, input logic ones);
    if (!ones) return {CRC_W{1'b0}};
    return (poly_sel_e'(sel) == POLY_C16) ? RESID_C16 : RESID_CCITT;
  endfunction

endpackage

// File: rtl/crc_lane.sv
module crc_lane
  import crc_eng_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      poly_sel,
  input  logic      preset_ones,
  input  logic      preset_cmd,
  input  logic      bit_en,
  input  logic      bit_in,
  output crc_word_t crc_q,
  output logic      load_evt,
  output logic      fold_evt
);

  crc_word_t crc_d;

  // Preset wins over a data bit in the same cycle
  always_comb begin
    load_evt = preset_cmd;
    fold_evt = bit_en & ~preset_cmd;
    if (load_evt)      crc_d = preset_word(preset_ones);
    else if (fold_evt) crc_d = fold_bit(crc_q, bit_in, poly_sel);
    else               crc_d = crc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/crc_residue_cmp.sv
module crc_residue_cmp
  import crc_eng_pkg::*;
(
  input  crc_word_t crc_val,
  input  logic      poly_sel,
  input  logic      preset_ones,
  output logic      match
);

  crc_word_t expect_w;

  always_comb begin
    expect_w = residue_word(poly_sel, preset_ones);
    match    = (crc_val == expect_w);
  end

endmodule

// File: rtl/crc_dual_engine.sv
module crc_dual_engine
  import crc_eng_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poly_sel,
  input  logic        preset_ones,
  input  logic        tx_preset_cmd,
  input  logic        tx_bit_en,
  input  logic        tx_bit,
  input  logic        rx_preset_cmd,
  input  logic        rx_bit_en,
  input  logic        rx_bit,
  output logic [15:0] tx_crc,
  output logic [15:0] rx_crc,
  output logic        rx_residue_ok
);

  localparam int TX_IX = 0;
  localparam int RX_IX = LANES - 1;

  logic [LANES-1:0] lane_cmd;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_bit;
  logic [LANES-1:0] lane_load;
  logic [LANES-1:0] lane_fold;
  crc_word_t        lane_crc [LANES];

  assign lane_cmd = {rx_preset_cmd, tx_preset_cmd};
  assign lane_en  = {rx_bit_en, tx_bit_en};
  assign lane_bit = {rx_bit, tx_bit};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crc_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .poly_sel    (poly_sel),
      .preset_ones (preset_ones),
      .preset_cmd  (lane_cmd[g]),
      .bit_en      (lane_en[g]),
      .bit_in      (lane_bit[g]),
      .crc_q       (lane_crc[g]),
      .load_evt    (lane_load[g]),
      .fold_evt    (lane_fold[g])
    );
  end

  assign tx_crc = lane_crc[TX_IX];
  assign rx_crc = lane_crc[RX_IX];

  crc_residue_cmp u_resid (
    .crc_val     (lane_crc[RX_IX]),
    .poly_sel    (poly_sel),
    .preset_ones (preset_ones),
    .match       (rx_residue_ok)
  );

endmodule

// File: rtl/crc_dual_engine_sva.sv
module crc_dual_engine_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        preset_ones,
  input logic        tx_preset_cmd,
  input logic        tx_bit_en,
  input logic        tx_bit,
  input logic        rx_preset_cmd,
  input logic        rx_bit_en,
  input logic [15:0] tx_crc,
  input logic [15:0] rx_crc,
  input logic        rx_residue_ok,
  input logic [1:0]  lane_fold,
  input logic [1:0]  lane_load
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_crc == 16'h0000 && rx_crc == 16'h0000)); // R4

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_preset_cmd && !tx_bit_en) |=> $stable(tx_crc)); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_preset_cmd && !rx_bit_en) |=> $stable(rx_crc)); // R5

  AST_TX_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_preset_cmd |=> (tx_crc == ($past(preset_ones) ? 16'hFFFF : 16'h0000))); // R3

  AST_RX_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_preset_cmd |=> (rx_crc == ($past(preset_ones) ? 16'hFFFF : 16'h0000))); // R3

  AST_PRESET_BEATS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_preset_cmd && tx_bit_en) |=> (tx_crc == 16'hFFFF || tx_crc == 16'h0000)); // R6

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lane_fold[0], lane_load[0]}) && $onehot0({lane_fold[1], lane_load[1]})); // R6

  AST_ZERO_FEEDBACK_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bit_en && !tx_preset_cmd && (tx_crc[0] == tx_bit)) |=>
      (tx_crc == ($past(tx_crc) >> 1))); // R1

  AST_ZERO_PRESET_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_preset_cmd && !preset_ones) |=> (preset_ones || rx_residue_ok)); // R7

endmodule

bind crc_dual_engine crc_dual_engine_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .preset_ones   (preset_ones),
  .tx_preset_cmd (tx_preset_cmd),
  .tx_bit_en     (tx_bit_en),
  .tx_bit        (tx_bit),
  .rx_preset_cmd (rx_preset_cmd),
  .rx_bit_en     (rx_bit_en),
  .tx_crc        (tx_crc),
  .rx_crc        (rx_crc),
  .rx_residue_ok (rx_residue_ok),
  .lane_fold     (lane_fold),
  .lane_load     (lane_load)
);

// File: tb/test_crc_dual_engine.sv
`timescale 1ns/1ps
module test_crc_dual_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poly_sel = 1'b0, preset_ones = 1'b0;
  logic        tx_preset_cmd = 1'b0, tx_bit_en = 1'b0, tx_bit = 1'b0;
  logic        rx_preset_cmd = 1'b0, rx_bit_en = 1'b0, rx_bit = 1'b0;
  logic [15:0] tx_crc, rx_crc;
  logic        rx_residue_ok;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  crc_dual_engine i_crc_dual_engine (
    .clk, .rst_n, .poly_sel, .preset_ones,
    .tx_preset_cmd, .tx_bit_en, .tx_bit,
    .rx_preset_cmd, .rx_bit_en, .rx_bit,
    .tx_crc, .rx_crc, .rx_residue_ok
  );

  // {poly_sel, preset_ones, expected CRC of ASCII "123456789"}
  localparam logic [17:0] VEC [4] = '{
    {1'b1, 1'b0, 16'hBB3D},
    {1'b0, 1'b0, 16'h2189},
    {1'b1, 1'b1, 16'h4B37},
    {1'b0, 1'b1, 16'h6F91}
  };

  // Reference model, restated with a mask instead of a conditional
  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic b,
                                           input logic sel);
    logic [15:0] p;
    p = sel ? 16'hA001 : 16'h8408;
    return {1'b0, c[15:1]} ^ ({16{c[0] ^ b}} & p);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive after the falling edge, sample 2 ns after the rising edge
  task automatic cyc(input logic tc, input logic te, input logic tb,
                     input logic rc, input logic re, input logic rb);
    @(negedge clk);
    tx_preset_cmd = tc; tx_bit_en = te; tx_bit = tb;
    rx_preset_cmd = rc; rx_bit_en = re; rx_bit = rb;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    tx_preset_cmd = 0; tx_bit_en = 0; rx_preset_cmd = 0; rx_bit_en = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] m, e;
    logic [7:0]  pat;
    poly_sel = 1; preset_ones = 1;
    repeat (3) @(posedge clk);
    #2;
    chk("R4 tx after reset", tx_crc, 16'h0000);
    chk("R4 rx after reset", rx_crc, 16'h0000);
    chk("R7 flag low, ones preset, reg 0", {15'd0, rx_residue_ok}, 16'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk("R4 no auto preset", tx_crc, 16'h0000);

    // R4: fold without command starts from zero despite ones preset
    m = 16'h0000; pat = 8'hA5;
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, pat[i], 0, 0, 0);
      m = ref_fold(m, pat[i], 1'b1);
    end
    idle();
    chk("R4 fold from reset value", tx_crc, m);

    // Table walk: R1, R2, R3, R7
    for (int v = 0; v < 4; v++) begin
      poly_sel = VEC[v][17]; preset_ones = VEC[v][16]; e = VEC[v][15:0];
      cyc(1, 0, 0, 1, 0, 0);
      chk("R3 preset value", tx_crc, preset_ones ? 16'hFFFF : 16'h0000);
      for (int k = 0; k < 9; k++) begin
        for (int i = 0; i < 8; i++) begin
          pat = 8'h31 + 8'(k);
          cyc(0, 1, pat[i], 0, 1, pat[i]);
        end
      end
      idle(); #1;
      chk("R1 tx check value", tx_crc, e);
      chk("R2 rx matches tx", rx_crc, e);
      chk("R7 flag low before CRC", {15'd0, rx_residue_ok}, 16'd0);
      m = preset_ones ? ~e : e;
      for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, m[i]);
      idle(); #1;
      chk("R7 flag after CRC", {15'd0, rx_residue_ok}, 16'd1);
      chk("R7 residue value", rx_crc,
          !preset_ones ? 16'h0000 : (poly_sel ? 16'hB001 : 16'hF0B8));
    end

    // R5: gated strobe with toggling data
    poly_sel = 0; preset_ones = 1;
    cyc(1, 0, 0, 0, 0, 0);
    m = 16'hFFFF; pat = 8'h3C;
    for (int i = 0; i < 16; i++) begin
      cyc(0, pat[i % 8] ^ i[0], i[1], 0, 0, 0);
      if (pat[i % 8] ^ i[0]) m = ref_fold(m, i[1], 1'b0);
    end
    idle(); #1;
    chk("R5 gated strobe stream", tx_crc, m);
    e = rx_crc;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, 1);
    chk("R5 tx held with enable low", tx_crc, m);
    chk("R5 rx held with enable low", rx_crc, e);

    // R6: preset and bit together
    cyc(1, 1, 1, 1, 1, 0);
    chk("R6 tx preset wins", tx_crc, 16'hFFFF);
    chk("R6 rx preset wins", rx_crc, 16'hFFFF);
    preset_ones = 0;
    cyc(1, 1, 1, 0, 0, 0);
    chk("R3 zero preset with bit", tx_crc, 16'h0000);

    // R8: value unchanged before the edge, updated right after
    poly_sel = 1;
    @(negedge clk);
    tx_preset_cmd = 0; tx_bit_en = 1; tx_bit = 1;
    #2;
    chk("R8 before edge", tx_crc, 16'h0000);
    @(posedge clk); #2;
    chk("R8 after edge", tx_crc, ref_fold(16'h0000, 1'b1, 1'b1));
    idle();

    // R7: zero preset leaves register at the zero residue
    cyc(0, 0, 0, 1, 0, 0);
    idle(); #1;
    chk("R7 zero preset flag", {15'd0, rx_residue_ok}, 16'd1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule